// File: doc/BRIEF.md
# Monitor Control Register Access Gate

This block decides, in a single combinational step, what happens when software reads or writes the control register of one selected system performance monitor instance. It looks at the privilege level making the access, whether the access is a read or a write, and which higher privilege levels exist or are enabled. It also takes the monitor enable bits of levels 1, 2 and 3, the fine-grained trap controls, and a 2-bit access-permission code per monitor instance held by the access-control registers of levels 1, 2 and 3. From these it picks exactly one outcome: the access goes ahead, the access is undefined, or the access traps to a higher level. A trap always carries exception class 0x18.

The checks run in a fixed priority order, and that order depends on the level making the access. Level 0 passes through the most stages. Level 3 is never stopped once the features are present. Two override inputs change how level-3 denials are reported. One lets a level-3 denial win ahead of every lower check. The other reports a level-3 denial as undefined instead of trapping. Register storage and exception entry are handled by neighbouring logic that consumes the verdict.

Top module: `spm_ctl_access_gate`

## Requirements
- R1: When either the monitor feature input or the 64-bit execution feature input is 0, every access gives verdict 01 (undefined), target level 00 and class 0. Verdict encoding: 00 permitted, 01 undefined, 10 trap.
- R2: An access code of 00 denies reads. Any access code other than 11 denies writes.
- R3: The access code used for instance index k is bits [2k+1:2k] of each level's access vector.
- R4: A trap reports class 0x18 and a target level above the accessing level. Any other verdict reports target 00 and class 0.
- R5: At level 0, the level-1 stage fires when the level-1 monitor enable is 0, or when the level-1 code denies and the host-context input is 0. The trap goes to level 2 if level 2 is enabled and the host-route input is 1, and to level 1 otherwise.
- R6: At levels 0 and 1, the fine-grained stage traps to level 2 when fine-grained support is present, level 2 is enabled, and either level 3 exists with its fine-grained enable at 0 or the read/write-specific fine-grained bit is 0. At level 0 this stage is skipped in host context.
- R7: At levels 0 and 1, the level-2 stage traps to level 2 when level 2 is enabled and either the level-2 monitor enable is 0 or the level-2 code denies.
- R8: At levels 0, 1 and 2, the level-3 stage fires when level 3 exists and either the level-3 monitor enable is 0 or the level-3 code denies. It traps to level 3, or gives undefined when the undefined-select input is 1.
- R9: At levels 0, 1 and 2, with the early-priority input at 1, the level-3 stage condition is evaluated before every other stage and gives undefined.
- R10: At level 3, every access is permitted when both features are present.
- R11: Stages are taken in the order early level-3, level-1, fine-grained, level-2, late level-3. The first stage that fires decides the verdict. When no stage fires, the access is permitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| acc_lvl | input | 2 | Privilege level of the access (0 to 3) |
| is_write | input | 1 | 1 for a write, 0 for a read |
| feat_mon | input | 1 | Monitor feature present |
| feat_64 | input | 1 | 64-bit execution feature present |
| has_lvl3 | input | 1 | Level 3 exists |
| lvl2_en | input | 1 | Level 2 enabled in the current state |
| host_ctx | input | 1 | Level 0 runs in the host context |
| host_route | input | 1 | Route level-0 traps to level 2 |
| l1_mon_en | input | 1 | Level-1 monitor enable |
| l2_mon_en | input | 1 | Level-2 monitor enable |
| l3_mon_en | input | 1 | Level-3 monitor enable |
| fg_present | input | 1 | Fine-grained trap support present |
| fg_l3_en | input | 1 | Level-3 fine-grained enable |
| fg_rd_ok | input | 1 | Fine-grained read bit for this register (0 traps) |
| fg_wr_ok | input | 1 | Fine-grained write bit for this register (0 traps) |
| l3_early | input | 1 | Check level-3 denial first, as undefined |
| l3_undef | input | 1 | Report a late level-3 denial as undefined |
| inst_sel | input | SEL_W | Selected monitor instance index |
| l1_codes | input | 2*NUM_INST | Level-1 access codes, 2 bits per instance |
| l2_codes | input | 2*NUM_INST | Level-2 access codes, 2 bits per instance |
| l3_codes | input | 2*NUM_INST | Level-3 access codes, 2 bits per instance |
| verdict | output | 2 | 00 permitted, 01 undefined, 10 trap |
| target_lvl | output | 2 | Trap target level, 0 when not trapping |
| exc_class | output | 6 | Exception class, 0x18 on trap |

## Verification
The main sweep walks every combination of the sixteen level, direction and control inputs. Each step pairs them with hashed access codes placed at a hashed instance index, and fills the other slots with different codes. Every stage of the chain therefore meets both firing and quiet neighbours, at every level and in both directions. An offset error in the field selection, a swapped stage order or a wrong route target then gives a verdict different from the bench's stage-by-stage model. Directed vectors cover the missing-feature case, level 3, the read/write split of codes 01 and 10, and one slot surrounded by opposite codes.

// File: rtl/spm_gate_pkg.sv
package spm_gate_pkg;
  typedef enum logic [1:0] {
    VERD_PERMIT = 2'b00,
    VERD_UNDEF  = 2'b01,
    VERD_TRAP   = 2'b10
  } verdict_e;

  localparam logic [5:0] TRAP_CLASS  = 6'h18;
  localparam int         NUM_LEVELS  = 3;
  localparam int         CODE_W      = 2;

  // Read needs any non-zero code; write needs full access.
  function automatic logic code_denies(input logic [CODE_W-1:0] code, input logic wr);
    return wr ? (code != 2'b11) : (code == 2'b00);
  endfunction
endpackage

// File: rtl/spm_field_pick.sv
module spm_field_pick #(
  parameter int NUM_INST = 4,
  parameter int SEL_W    = (NUM_INST > 1) ? $clog2(NUM_INST) : 1
) (
  input  logic [2*NUM_INST-1:0] codes_vec,
  input  logic [SEL_W-1:0]      sel,
  output logic [1:0]            code
);
  logic [1:0] slot [NUM_INST];

  genvar g;
  generate
    for (g = 0; g < NUM_INST; g++) begin : g_slot
      assign slot[g] = codes_vec[2*g +: 2];
    end
    if (NUM_INST == (1 << SEL_W)) begin : g_full
      assign code = slot[sel];
    end else begin : g_partial
      assign code = (int'(sel) < NUM_INST) ? slot[sel] : 2'b00;
    end
  endgenerate
endmodule

// File: rtl/spm_deny_eval.sv
module spm_deny_eval
  import spm_gate_pkg::*;
(
  input  logic [1:0] code,
  input  logic       is_write,
  input  logic       mon_en,
  input  logic       stage_on,
  output logic       code_deny,
  output logic       stage_hit
);
  always_comb begin
    code_deny = code_denies(code, is_write);
    stage_hit = stage_on && (!mon_en || code_deny);
  end
endmodule

// File: rtl/spm_trap_chain.sv
module spm_trap_chain
  import spm_gate_pkg::*;
(
  input  logic [1:0] acc_lvl,
  input  logic       is_write,
  input  logic       feats_ok,
  input  logic       has_lvl3,
  input  logic       lvl2_en,
  input  logic       host_ctx,
  input  logic       host_route,
  input  logic       l1_mon_en,
  input  logic       l1_deny,
  input  logic       l2_hit,
  input  logic       l3_hit,
  input  logic       fg_present,
  input  logic       fg_l3_en,
  input  logic       fg_rd_ok,
  input  logic       fg_wr_ok,
  input  logic       l3_early,
  input  logic       l3_undef,
  output verdict_e   verdict,
  output logic [1:0] target_lvl
);
  logic below_l2;
  logic lvl1_hit;
  logic fg_bit_ok;
  logic fg_hit;
  logic route_l2;

  assign below_l2  = (acc_lvl == 2'd0) || (acc_lvl == 2'd1);
  assign lvl1_hit  = (acc_lvl == 2'd0) && (!l1_mon_en || (l1_deny && !host_ctx));
  assign fg_bit_ok = is_write ? fg_wr_ok : fg_rd_ok;
  assign fg_hit    = below_l2 && fg_present && lvl2_en
                     && !((acc_lvl == 2'd0) && host_ctx)
                     && ((has_lvl3 && !fg_l3_en) || !fg_bit_ok);
  assign route_l2  = lvl2_en && host_route;

  always_comb begin
    verdict    = VERD_PERMIT;
    target_lvl = 2'd0;
    if (!feats_ok) begin
      verdict = VERD_UNDEF;
    end else if (acc_lvl != 2'd3) begin
      if (l3_early && l3_hit) begin
        verdict = VERD_UNDEF;
      end else if (lvl1_hit) begin
        verdict    = VERD_TRAP;
        target_lvl = route_l2 ? 2'd2 : 2'd1;
      end else if (fg_hit || (below_l2 && l2_hit)) begin
        verdict    = VERD_TRAP;
        target_lvl = 2'd2;
      end else if (l3_hit) begin
        if (l3_undef) begin
          verdict = VERD_UNDEF;
        end else begin
          verdict    = VERD_TRAP;
          target_lvl = 2'd3;
        end
      end
    end
  end
endmodule

// File: rtl/spm_ctl_access_gate.sv
module spm_ctl_access_gate
  import spm_gate_pkg::*;
#(
  parameter int NUM_INST = 4,
  parameter int SEL_W    = (NUM_INST > 1) ? $clog2(NUM_INST) : 1
) (
  input  logic [1:0]            acc_lvl,
  input  logic                  is_write,
  input  logic                  feat_mon,
  input  logic                  feat_64,
  input  logic                  has_lvl3,
  input  logic                  lvl2_en,
  input  logic                  host_ctx,
  input  logic                  host_route,
  input  logic                  l1_mon_en,
  input  logic                  l2_mon_en,
  input  logic                  l3_mon_en,
  input  logic                  fg_present,
  input  logic                  fg_l3_en,
  input  logic                  fg_rd_ok,
  input  logic                  fg_wr_ok,
  input  logic                  l3_early,
  input  logic                  l3_undef,
  input  logic [SEL_W-1:0]      inst_sel,
  input  logic [2*NUM_INST-1:0] l1_codes,
  input  logic [2*NUM_INST-1:0] l2_codes,
  input  logic [2*NUM_INST-1:0] l3_codes,
  output logic [1:0]            verdict,
  output logic [1:0]            target_lvl,
  output logic [5:0]            exc_class
);
  localparam int VEC_W = 2 * NUM_INST;

  logic [VEC_W-1:0] lvl_vec  [NUM_LEVELS];
  logic             lvl_men  [NUM_LEVELS];
  logic             lvl_on   [NUM_LEVELS];
  logic [1:0]       lvl_code [NUM_LEVELS];
  logic             lvl_deny [NUM_LEVELS];
  logic             lvl_hit  [NUM_LEVELS];
  verdict_e         chain_v;
  logic [1:0]       chain_t;

  assign lvl_vec[0] = l1_codes;
  assign lvl_vec[1] = l2_codes;
  assign lvl_vec[2] = l3_codes;
  assign lvl_men[0] = l1_mon_en;
  assign lvl_men[1] = l2_mon_en;
  assign lvl_men[2] = l3_mon_en;
  assign lvl_on[0]  = 1'b1;
  assign lvl_on[1]  = lvl2_en;
  assign lvl_on[2]  = has_lvl3;

  genvar lv;
  generate
    for (lv = 0; lv < NUM_LEVELS; lv++) begin : g_lvl
      spm_field_pick #(.NUM_INST(NUM_INST), .SEL_W(SEL_W)) u_pick (
        .codes_vec (lvl_vec[lv]),
        .sel       (inst_sel),
        .code      (lvl_code[lv])
      );
      spm_deny_eval u_deny (
        .code      (lvl_code[lv]),
        .is_write  (is_write),
        .mon_en    (lvl_men[lv]),
        .stage_on  (lvl_on[lv]),
        .code_deny (lvl_deny[lv]),
        .stage_hit (lvl_hit[lv])
      );
    end
  endgenerate

  spm_trap_chain u_chain (
    .acc_lvl    (acc_lvl),
    .is_write   (is_write),
    .feats_ok   (feat_mon && feat_64),
    .has_lvl3   (has_lvl3),
    .lvl2_en    (lvl2_en),
    .host_ctx   (host_ctx),
    .host_route (host_route),
    .l1_mon_en  (l1_mon_en),
    .l1_deny    (lvl_deny[0]),
    .l2_hit     (lvl_hit[1]),
    .l3_hit     (lvl_hit[2]),
    .fg_present (fg_present),
    .fg_l3_en   (fg_l3_en),
    .fg_rd_ok   (fg_rd_ok),
    .fg_wr_ok   (fg_wr_ok),
    .l3_early   (l3_early),
    .l3_undef   (l3_undef),
    .verdict    (chain_v),
    .target_lvl (chain_t)
  );

  assign verdict    = chain_v;
  assign target_lvl = chain_t;
  assign exc_class  = (chain_v == VERD_TRAP) ? TRAP_CLASS : 6'h00;

  always_comb begin
    a_r1_absent_undef: assert (feat_mon && feat_64 || verdict == 2'b01)
      else $error("R1: missing feature did not give undefined");
    a_r4_trap_above: assert (verdict != 2'b10 || target_lvl > acc_lvl)
      else $error("R4: trap target not above accessing level");
    a_r4_quiet_target: assert (verdict == 2'b10 || (target_lvl == 2'd0 && exc_class == 6'h00))
      else $error("R4: non-trap verdict carries a target or class");
    a_r10_top_permit: assert (!(feat_mon && feat_64 && acc_lvl == 2'd3) || verdict == 2'b00)
      else $error("R10: level 3 access not permitted");
    a_r7_target2_needs_l2: assert (!(verdict == 2'b10 && target_lvl == 2'd2) || lvl2_en)
      else $error("R7: trap to level 2 while level 2 disabled");
    a_r8_target3_needs_l3: assert (!(verdict == 2'b10 && target_lvl == 2'd3) || has_lvl3)
      else $error("R8: trap to level 3 while level 3 absent");
    a_r9_early_undef: assert (!(feat_mon && feat_64 && acc_lvl != 2'd3 && l3_early
                                && has_lvl3 && (!l3_mon_en || lvl_deny[2]))
                              || verdict == 2'b01)
      else $error("R9: early level-3 denial not undefined");
    a_r11_legal_verdict: assert (verdict != 2'b11)
      else $error("R11: reserved verdict encoding");
  end
endmodule

// File: tb/spm_ctl_access_gate_test.sv
module spm_ctl_access_gate_test;
  localparam int CLK_PERIOD = 10;
  localparam int NI = 4;
  localparam int SW = 2;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [1:0] acc_lvl;
  logic is_write, feat_mon, feat_64, has_lvl3, lvl2_en, host_ctx, host_route;
  logic l1_mon_en, l2_mon_en, l3_mon_en, fg_present, fg_l3_en, fg_rd_ok, fg_wr_ok;
  logic l3_early, l3_undef;
  logic [SW-1:0]   inst_sel;
  logic [2*NI-1:0] l1_codes, l2_codes, l3_codes;
  logic [1:0] verdict, target_lvl;
  logic [5:0] exc_class;

  logic [1:0] c1, c2, c3;
  int checks = 0;
  int errors = 0;

  spm_ctl_access_gate #(.NUM_INST(NI), .SEL_W(SW)) uut (.*);

  function automatic logic denied(input logic [1:0] c, input logic w);
    if (w) return !(c[1] & c[0]);
    return !(c[1] | c[0]);
  endfunction

  task automatic model(output logic [1:0] ev, output logic [1:0] et, output string tag);
    logic l3cond;
    logic fgcond;
    l3cond = has_lvl3 && (!l3_mon_en || denied(c3, is_write));
    fgcond = fg_present && lvl2_en && ((has_lvl3 && !fg_l3_en) || !(is_write ? fg_wr_ok : fg_rd_ok));
    ev = 2'b00; et = 2'd0; tag = "R11";
    if (!(feat_mon && feat_64)) begin ev = 2'b01; tag = "R1"; return; end
    if (acc_lvl == 2'd3) begin tag = "R10"; return; end
    if (l3_early && l3cond) begin ev = 2'b01; tag = "R9"; return; end
    if (acc_lvl == 2'd0 && (!l1_mon_en || (!host_ctx && denied(c1, is_write)))) begin
      ev = 2'b10; et = (lvl2_en && host_route) ? 2'd2 : 2'd1; tag = "R5"; return;
    end
    if (acc_lvl != 2'd2) begin
      if (fgcond && !(acc_lvl == 2'd0 && host_ctx)) begin ev = 2'b10; et = 2'd2; tag = "R6"; return; end
      if (lvl2_en && (!l2_mon_en || denied(c2, is_write))) begin ev = 2'b10; et = 2'd2; tag = "R7"; return; end
    end
    if (l3cond) begin
      tag = "R8";
      if (l3_undef) ev = 2'b01;
      else begin ev = 2'b10; et = 2'd3; end
    end
  endtask

  task automatic fill(input logic [31:0] h);
    l1_codes = h[7:0];
    l2_codes = ~h[15:8];
    l3_codes = h[23:16] ^ 8'h5A;
    l1_codes[2*inst_sel +: 2] = c1;
    l2_codes[2*inst_sel +: 2] = c2;
    l3_codes[2*inst_sel +: 2] = c3;
  endtask

  task automatic check(input string why);
    logic [1:0] ev, et;
    string tag;
    @(negedge clk);
    model(ev, et, tag);
    checks++;
    if (verdict !== ev || target_lvl !== et) begin
      errors++;
      $display("FAIL %s (%s) lvl=%0d wr=%0b: verdict/target %b/%0d expected %b/%0d",
               tag, why, acc_lvl, is_write, verdict, target_lvl, ev, et);
    end
    checks++;
    if (exc_class !== ((ev == 2'b10) ? 6'h18 : 6'h00)) begin
      errors++;
      $display("FAIL R4 (%s): class %h expected %h", why, exc_class,
               (ev == 2'b10) ? 6'h18 : 6'h00);
    end
    @(posedge clk);
  endtask

  task automatic all_clear();
    acc_lvl = 0; is_write = 0; feat_mon = 1; feat_64 = 1; has_lvl3 = 1; lvl2_en = 1;
    host_ctx = 0; host_route = 0; l1_mon_en = 1; l2_mon_en = 1; l3_mon_en = 1;
    fg_present = 1; fg_l3_en = 1; fg_rd_ok = 1; fg_wr_ok = 1; l3_early = 0; l3_undef = 0;
    inst_sel = 0; c1 = 2'b11; c2 = 2'b11; c3 = 2'b11; fill(32'h0);
  endtask

  task automatic run_main();
    // reset state: every input low, features absent -> undefined (R1)
    acc_lvl = 0; is_write = 0; feat_mon = 0; feat_64 = 0; has_lvl3 = 0; lvl2_en = 0;
    host_ctx = 0; host_route = 0; l1_mon_en = 0; l2_mon_en = 0; l3_mon_en = 0;
    fg_present = 0; fg_l3_en = 0; fg_rd_ok = 0; fg_wr_ok = 0; l3_early = 0; l3_undef = 0;
    inst_sel = 0; c1 = 0; c2 = 0; c3 = 0; l1_codes = 0; l2_codes = 0; l3_codes = 0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    check("R1 reset state");

    all_clear(); feat_64 = 0; acc_lvl = 2'd3; check("R1 no 64-bit feature");
    all_clear(); feat_mon = 0; check("R1 no monitor feature");
    all_clear(); acc_lvl = 2'd3; l3_mon_en = 0; fg_present = 1; fg_rd_ok = 0; check("R10 level 3");
    // R2: code 01 allows read, denies write; code 10 same
    all_clear(); acc_lvl = 2'd2; c3 = 2'b01; fill(32'hFFFF_FFFF); check("R2 read code 01");
    is_write = 1; fill(32'hFFFF_FFFF); check("R2 write code 01");
    c3 = 2'b10; fill(32'h0); check("R2 write code 10");
    // R3: one denying slot among full-access slots
    all_clear(); inst_sel = 2; c1 = 2'b00; fill(32'h0);
    l1_codes = 8'hFF; l1_codes[5:4] = 2'b00; check("R3 slot 2 denies");
    inst_sel = 1; c1 = 2'b11; check("R3 slot 1 open");

    for (int i = 0; i < 65536; i++) begin
      logic [31:0] h;
      h = i * 32'h9E37_79B1 + 32'h1234_5678;
      acc_lvl = i[1:0]; is_write = i[2]; host_ctx = i[3]; host_route = i[4];
      has_lvl3 = i[5]; lvl2_en = i[6]; l1_mon_en = i[7]; l2_mon_en = i[8];
      l3_mon_en = i[9]; fg_present = i[10]; fg_l3_en = i[11]; fg_rd_ok = i[12];
      fg_wr_ok = i[13]; l3_early = i[14]; l3_undef = i[15];
      feat_mon = 1; feat_64 = 1;
      c1 = h[31:30]; c2 = h[29:28]; c3 = h[27:26]; inst_sel = h[25:24];
      fill(h);
      check("R5 R6 R7 R8 R9 sweep");
    end
  endtask

  initial begin
    fork
      run_main();
      begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete, actual hung expected done");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule